// File: doc/BRIEF.md
# Interlocked Three-Stage ALU Pipeline with Optional Result Bypass

This block is a short in-order execution pipeline for register-to-register instructions. Each instruction names an operation (add or multiply on 16-bit words), a destination temporary register, and two sources. Each source selects either a writable temporary register or a read-only constant register. An instruction is taken on a valid/ready handshake. That cycle is its operand fetch clock, in which the sources are read. It then spends three clocks in a pipelined arithmetic unit. In the fifth clock it stores its result into the destination register, and the same result is shown on a debug writeback port.

A pending-write bit per temporary register tracks results still in flight. The bit is set when an instruction issues and cleared when that instruction stores. The ready signal is withheld from any instruction that would read a stale temporary, or that would overwrite a register whose earlier write has not yet reached its store clock. A build-time switch adds a path from the final arithmetic result back into operand fetch. With that path, a dependent instruction may fetch during its producer's store clock instead of the clock after it, which cuts a back-to-back dependency stall from four cycles to three.

Constant register k holds the value (k+1) × 0x0101, truncated to 16 bits. Constant registers never take part in hazard detection.

Top module: `alu_pipe`

## Requirements
- R1: After reset, all temporary registers hold zero. wb_valid is low. in_ready is high for any instruction.
- R2: in_op = 0 adds and in_op = 1 multiplies, keeping the low 16 bits. A select bit of 0 reads temporary register idx. A select bit of 1 reads constant register idx, whose value is (idx+1) × 0x0101.
- R3: For an instruction that handshakes in clock c, wb_valid is high in clock c+4 with its destination and result. The temporary register holds the new value from clock c+5.
- R4: Without bypass, an instruction that reads the destination of the instruction just issued before it handshakes five cycles after that producer, which is four stall cycles.
- R5: With bypass, such a dependent instruction handshakes four cycles after its producer, which is three stall cycles. It receives the final arithmetic result, on either source.
- R6: With bypass, a consumer that follows its producer after three independent instructions issues with no stall. Without bypass, the same consumer stalls exactly one cycle.
- R7: A constant-register source never stalls issue, even when its index equals that of a temporary register with a pending write.
- R8: An instruction whose destination has a pending write handshakes in the store clock of that write, four cycles after it, in both modes.
- R9: Instructions that share no registers with any in-flight instruction handshake on consecutive cycles.
- R10: The writeback port reports results in issue order, and each result equals the one produced by executing the instructions one at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction may issue this cycle |
| in_op | input | 1 | 0 = add, 1 = multiply |
| in_dst | input | 3 | Destination temporary register |
| in_a_sel | input | 1 | Source A: 0 = temporary, 1 = constant |
| in_a_idx | input | 3 | Source A register index |
| in_b_sel | input | 1 | Source B: 0 = temporary, 1 = constant |
| in_b_idx | input | 3 | Source B register index |
| wb_valid | output | 1 | A result is being stored this cycle |
| wb_dst | output | 3 | Register being stored |
| wb_data | output | 16 | Value being stored |

## Verification
The hardest case to reach from the ports is the store clock of a producer. In that one cycle the forwarded value, the register-file write, the clearing of the pending bit and a possible overlapping new writer to the same register all coincide. The stimulus reaches it on purpose in two ways. First, it offers a dependent instruction immediately after its producer on each source side. Second, it places exactly three independent instructions between a producer and its consumer. A later overwrite of the same register, and an immediate read of that overwritten register, land on the same cycle from a different direction. A pseudo-random stream then mixes all these cases. Its results are compared one by one against a sequential model, and the issue-to-issue cycle gaps of the directed cases are checked against the expected stall counts.

// File: rtl/alu_pipe_pkg.sv
`timescale 1ns/1ps
package alu_pipe_pkg;

    localparam int DATA_W      = 16;
    localparam int HALF_W      = DATA_W / 2;
    localparam int REG_N       = 8;
    localparam int IDX_W       = $clog2(REG_N);
    localparam int ARITH_DEPTH = 3;
    localparam int WB_LAT      = ARITH_DEPTH + 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [IDX_W-1:0]  ridx_t;

    typedef enum logic {OP_ADD = 1'b0, OP_MUL = 1'b1} op_e;
    typedef enum logic {SRC_TMP = 1'b0, SRC_CON = 1'b1} srcsel_e;

    typedef struct packed {
        srcsel_e sel;
        ridx_t   idx;
    } src_t;

    typedef struct packed {
        op_e   op;
        ridx_t dst;
        src_t  a;
        src_t  b;
    } instr_t;

    // operands captured at the end of the fetch clock
    typedef struct packed {
        logic  vld;
        op_e   op;
        ridx_t dst;
        word_t a;
        word_t b;
    } opnd_stage_t;

    // after arithmetic step 1: sum and two partial products
    typedef struct packed {
        logic  vld;
        op_e   op;
        ridx_t dst;
        word_t sum;
        word_t pp_lo;
        half_t pp_hi;
    } part_stage_t;

    // after arithmetic step 2: both candidate results
    typedef struct packed {
        logic  vld;
        op_e   op;
        ridx_t dst;
        word_t sum;
        word_t prod;
    } comb_stage_t;

    // after arithmetic step 3: final result, held through the store clock
    typedef struct packed {
        logic  vld;
        ridx_t dst;
        word_t res;
    } res_stage_t;

    localparam word_t CONST_STEP = word_t'({(DATA_W/8){8'h01}});

    function automatic word_t const_value(ridx_t k);
        word_t base;
        base = word_t'(k) + word_t'(1);
        return base * CONST_STEP;
    endfunction

    function automatic logic src_is_tmp(src_t s);
        return s.sel == SRC_TMP;
    endfunction

endpackage

// File: rtl/alu_pipe_regfile.sv
`timescale 1ns/1ps
module alu_pipe_regfile
    import alu_pipe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ridx_t waddr,
    input  word_t wdata,
    input  src_t  rd_a,
    input  src_t  rd_b,
    output word_t q_a,
    output word_t q_b
);

    word_t tmp_q [REG_N];
    word_t con_w [REG_N];

    generate
        for (genvar k = 0; k < REG_N; k++) begin : g_reg
            assign con_w[k] = const_value(ridx_t'(k));

            always_ff @(posedge clk) begin
                if (rst) begin
                    tmp_q[k] <= '0;
                end else if (we && waddr == ridx_t'(k)) begin
                    tmp_q[k] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        q_a = (rd_a.sel == SRC_CON) ? con_w[rd_a.idx] : tmp_q[rd_a.idx];
        q_b = (rd_b.sel == SRC_CON) ? con_w[rd_b.idx] : tmp_q[rd_b.idx];
    end

endmodule

// File: rtl/alu_pipe_scoreboard.sv
`timescale 1ns/1ps
module alu_pipe_scoreboard
    import alu_pipe_pkg::*;
#(
    parameter bit BYPASS = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  instr_t           instr,
    input  logic             issue_fire,
    input  res_stage_t       wb,
    output logic             ready,
    output logic             fwd_a,
    output logic             fwd_b,
    output logic [REG_N-1:0] pending
);

    logic [REG_N-1:0] wb_hit;
    logic [REG_N-1:0] fwd_ok;
    logic             raw_a;
    logic             raw_b;
    logic             waw;

    generate
        for (genvar k = 0; k < REG_N; k++) begin : g_bit
            assign wb_hit[k] = wb.vld && (wb.dst == ridx_t'(k));

            always_ff @(posedge clk) begin
                if (rst) begin
                    pending[k] <= 1'b0;
                end else if (issue_fire && instr.dst == ridx_t'(k)) begin
                    pending[k] <= 1'b1;
                end else if (wb_hit[k]) begin
                    pending[k] <= 1'b0;
                end
            end
        end

        if (BYPASS) begin : g_bypass
            assign fwd_ok = wb_hit;
        end else begin : g_no_bypass
            assign fwd_ok = '0;
        end
    endgenerate

    always_comb begin
        raw_a = src_is_tmp(instr.a) && pending[instr.a.idx] && !fwd_ok[instr.a.idx];
        raw_b = src_is_tmp(instr.b) && pending[instr.b.idx] && !fwd_ok[instr.b.idx];
        waw   = pending[instr.dst] && !wb_hit[instr.dst];
        ready = !(raw_a || raw_b || waw);
        fwd_a = src_is_tmp(instr.a) && fwd_ok[instr.a.idx];
        fwd_b = src_is_tmp(instr.b) && fwd_ok[instr.b.idx];
    end

    AST_SET_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
        issue_fire |=> pending[$past(instr.dst)]);                           // R8

    AST_CLEAR_ON_STORE: assert property (@(posedge clk) disable iff (rst)
        (wb.vld && !(issue_fire && instr.dst == wb.dst)) |=> !pending[$past(wb.dst)]); // R4

endmodule

// File: rtl/alu_pipe_arith.sv
`timescale 1ns/1ps
module alu_pipe_arith
    import alu_pipe_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  opnd_stage_t                         in_st,
    output res_stage_t                          res_q,
    output logic [ARITH_DEPTH-1:0]              fl_vld,
    output logic [ARITH_DEPTH-1:0][IDX_W-1:0]   fl_dst
);

    opnd_stage_t s1_q;
    part_stage_t s2_d, s2_q;
    comb_stage_t s3_d, s3_q;
    res_stage_t  s4_d;

    // step 1: sum, and the two partial products of the low 16 bits
    always_comb begin
        s2_d.vld   = s1_q.vld;
        s2_d.op    = s1_q.op;
        s2_d.dst   = s1_q.dst;
        s2_d.sum   = s1_q.a + s1_q.b;
        s2_d.pp_lo = s1_q.a * {{HALF_W{1'b0}}, s1_q.b[HALF_W-1:0]};
        s2_d.pp_hi = s1_q.a[HALF_W-1:0] * s1_q.b[DATA_W-1:HALF_W];
    end

    // step 2: combine partial products
    always_comb begin
        s3_d.vld  = s2_q.vld;
        s3_d.op   = s2_q.op;
        s3_d.dst  = s2_q.dst;
        s3_d.sum  = s2_q.sum;
        s3_d.prod = s2_q.pp_lo + {s2_q.pp_hi, {HALF_W{1'b0}}};
    end

    // step 3: pick the result of the requested operation
    always_comb begin
        s4_d.vld = s3_q.vld;
        s4_d.dst = s3_q.dst;
        s4_d.res = (s3_q.op == OP_MUL) ? s3_q.prod : s3_q.sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= '0;
            s2_q  <= '0;
            s3_q  <= '0;
            res_q <= '0;
        end else begin
            s1_q  <= in_st;
            s2_q  <= s2_d;
            s3_q  <= s3_d;
            res_q <= s4_d;
        end
    end

    always_comb begin
        fl_vld    = {s3_q.vld, s2_q.vld, s1_q.vld};
        fl_dst[0] = s1_q.dst;
        fl_dst[1] = s2_q.dst;
        fl_dst[2] = s3_q.dst;
    end

endmodule

// File: rtl/alu_pipe.sv
`timescale 1ns/1ps
module alu_pipe
    import alu_pipe_pkg::*;
#(
    parameter bit BYPASS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_op,
    input  logic [IDX_W-1:0]  in_dst,
    input  logic              in_a_sel,
    input  logic [IDX_W-1:0]  in_a_idx,
    input  logic              in_b_sel,
    input  logic [IDX_W-1:0]  in_b_idx,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_dst,
    output logic [DATA_W-1:0] wb_data
);

    instr_t                            cur;
    logic                              issue_fire;
    logic                              fwd_a, fwd_b;
    logic [REG_N-1:0]                  pending;
    word_t                             rf_a, rf_b;
    opnd_stage_t                       fetch_st;
    res_stage_t                        res_q;
    logic [ARITH_DEPTH-1:0]            fl_vld;
    logic [ARITH_DEPTH-1:0][IDX_W-1:0] fl_dst;

    always_comb begin
        cur.op    = op_e'(in_op);
        cur.dst   = in_dst;
        cur.a.sel = srcsel_e'(in_a_sel);
        cur.a.idx = in_a_idx;
        cur.b.sel = srcsel_e'(in_b_sel);
        cur.b.idx = in_b_idx;
    end

    assign issue_fire = in_valid && in_ready;

    alu_pipe_scoreboard #(.BYPASS(BYPASS)) sb_i (
        .clk        (clk),
        .rst        (rst),
        .instr      (cur),
        .issue_fire (issue_fire),
        .wb         (res_q),
        .ready      (in_ready),
        .fwd_a      (fwd_a),
        .fwd_b      (fwd_b),
        .pending    (pending)
    );

    alu_pipe_regfile rf_i (
        .clk   (clk),
        .rst   (rst),
        .we    (res_q.vld),
        .waddr (res_q.dst),
        .wdata (res_q.res),
        .rd_a  (cur.a),
        .rd_b  (cur.b),
        .q_a   (rf_a),
        .q_b   (rf_b)
    );

    // operand fetch: register file, or the final arithmetic result
    always_comb begin
        fetch_st.vld = issue_fire;
        fetch_st.op  = cur.op;
        fetch_st.dst = cur.dst;
        fetch_st.a   = fwd_a ? res_q.res : rf_a;
        fetch_st.b   = fwd_b ? res_q.res : rf_b;
    end

    alu_pipe_arith arith_i (
        .clk    (clk),
        .rst    (rst),
        .in_st  (fetch_st),
        .res_q  (res_q),
        .fl_vld (fl_vld),
        .fl_dst (fl_dst)
    );

    assign wb_valid = res_q.vld;
    assign wb_dst   = res_q.dst;
    assign wb_data  = res_q.res;

    // checking helpers: is any older writer of a source still unfinished?
    logic             stale_a, stale_b;
    logic [REG_N-1:0] tracked;

    always_comb begin
        stale_a = 1'b0;
        stale_b = 1'b0;
        for (int k = 0; k < ARITH_DEPTH; k++) begin
            if (fl_vld[k] && fl_dst[k] == cur.a.idx) stale_a = 1'b1;
            if (fl_vld[k] && fl_dst[k] == cur.b.idx) stale_b = 1'b1;
        end
        if (!BYPASS && res_q.vld && res_q.dst == cur.a.idx) stale_a = 1'b1;
        if (!BYPASS && res_q.vld && res_q.dst == cur.b.idx) stale_b = 1'b1;
        if (cur.a.sel == SRC_CON) stale_a = 1'b0;
        if (cur.b.sel == SRC_CON) stale_b = 1'b0;
    end

    always_comb begin
        for (int r = 0; r < REG_N; r++) begin
            tracked[r] = res_q.vld && res_q.dst == ridx_t'(r);
            for (int k = 0; k < ARITH_DEPTH; k++) begin
                if (fl_vld[k] && fl_dst[k] == ridx_t'(r)) tracked[r] = 1'b1;
            end
        end
    end

    AST_NO_STALE_READ: assert property (@(posedge clk) disable iff (rst)
        issue_fire |-> !(stale_a || stale_b));                               // R5

    AST_WB_LATENCY: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> ($past(issue_fire, WB_LAT) && $past(in_dst, WB_LAT) == wb_dst)); // R3

    AST_PENDING_TRACKED: assert property (@(posedge clk) disable iff (rst)
        (pending & ~tracked) == '0);                                         // R4

endmodule

// File: tb/alu_pipe_tb_top.sv
`timescale 1ns/1ps
module alu_pipe_harness
    import alu_pipe_pkg::*;
#(
    parameter bit BYPASS = 1'b1
) (
    input  logic clk,
    input  logic rst,
    output logic done,
    output int   n_checks,
    output int   n_fail
);

    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              in_op = 1'b0;
    logic [IDX_W-1:0]  in_dst = '0;
    logic              in_a_sel = 1'b0;
    logic [IDX_W-1:0]  in_a_idx = '0;
    logic              in_b_sel = 1'b0;
    logic [IDX_W-1:0]  in_b_idx = '0;
    logic              wb_valid;
    logic [IDX_W-1:0]  wb_dst;
    logic [DATA_W-1:0] wb_data;

    alu_pipe #(.BYPASS(BYPASS)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_op    (in_op),
        .in_dst   (in_dst),
        .in_a_sel (in_a_sel),
        .in_a_idx (in_a_idx),
        .in_b_sel (in_b_sel),
        .in_b_idx (in_b_idx),
        .wb_valid (wb_valid),
        .wb_dst   (wb_dst),
        .wb_data  (wb_data)
    );

    typedef struct {
        int    dst;
        int    data;
        int    cyc;
        string tag;
    } exp_t;

    exp_t  expq[$];
    int    cyc;
    int    model_t [REG_N];
    string mode = BYPASS ? "bypass" : "no-bypass";

    always_ff @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (%s): actual %0h expected %0h", tag, mode, act, exp_v);
        end
    endtask

    function automatic int opnd(input bit s, input int i);
        int v;
        v = s ? (((i + 1) * 32'h0101) & 32'hFFFF) : model_t[i];
        return v;
    endfunction

    task automatic issue(input bit op, input int dst, input bit as, input int ai,
                         input bit bs, input int bi, input string tag, output int hcyc);
        bit got;
        int a, b, r;
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_dst   = IDX_W'(dst);
        in_a_sel = as;
        in_a_idx = IDX_W'(ai);
        in_b_sel = bs;
        in_b_idx = IDX_W'(bi);
        got = 1'b0;
        while (!got) begin
            #1;
            if (in_ready) got = 1'b1;
            else @(negedge clk);
        end
        hcyc = cyc;
        a = opnd(as, ai);
        b = opnd(bs, bi);
        r = op ? ((a * b) & 32'hFFFF) : ((a + b) & 32'hFFFF);
        model_t[dst] = r;
        expq.push_back('{dst, r, hcyc + 4, tag});
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop and compare each stored result
    always @(negedge clk) begin
        if (!rst && wb_valid) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R10 unexpected writeback", int'(wb_dst), -1);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(int'(wb_dst) == e.dst, {e.tag, " R10 dst"}, int'(wb_dst), e.dst);
                chk(int'(wb_data) == e.data, {e.tag, " R2 R10 data"}, int'(wb_data), e.data);
                chk(cyc == e.cyc, {e.tag, " R3 store cycle"}, cyc, e.cyc);
            end
        end
    end

    initial begin
        int p, q, r0, r1, r2, r3, gap_dep;
        int lfsr;
        done = 1'b0;
        n_checks = 0;
        n_fail = 0;
        for (int i = 0; i < REG_N; i++) model_t[i] = 0;
        gap_dep = BYPASS ? 4 : 5;

        @(negedge clk);
        while (rst) @(negedge clk);
        #1;
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        chk(wb_valid == 1'b0, "R1 no writeback after reset", int'(wb_valid), 0);

        // R1: temporaries read as zero
        issue(1'b0, 1, 1'b0, 2, 1'b0, 3, "R1", p);
        idle(8);

        // R9: independent back-to-back issue
        issue(1'b0, 0, 1'b1, 0, 1'b1, 1, "R9", r0);
        issue(1'b1, 2, 1'b1, 2, 1'b1, 3, "R9", r1);
        issue(1'b0, 3, 1'b1, 4, 1'b1, 5, "R9", r2);
        issue(1'b1, 5, 1'b1, 6, 1'b1, 7, "R9", r3);
        chk(r1 - r0 == 1, "R9 gap 1", r1 - r0, 1);
        chk(r2 - r1 == 1, "R9 gap 2", r2 - r1, 1);
        chk(r3 - r2 == 1, "R9 gap 3", r3 - r2, 1);
        idle(8);

        // R4/R5: back-to-back dependency, then on the B side
        issue(1'b0, 6, 1'b0, 0, 1'b1, 3, "R4 R5", p);
        issue(1'b1, 7, 1'b0, 6, 1'b0, 2, "R4 R5", q);
        chk(q - p == gap_dep, BYPASS ? "R5 dependent gap A" : "R4 dependent gap A", q - p, gap_dep);
        issue(1'b0, 4, 1'b1, 1, 1'b0, 7, "R4 R5", r0);
        chk(r0 - q == gap_dep, BYPASS ? "R5 dependent gap B" : "R4 dependent gap B", r0 - q, gap_dep);
        idle(8);

        // R6: three independent instructions between producer and consumer
        issue(1'b1, 1, 1'b0, 2, 1'b0, 3, "R6", p);
        issue(1'b0, 4, 1'b1, 1, 1'b1, 2, "R6", r0);
        issue(1'b0, 5, 1'b1, 3, 1'b1, 4, "R6", r1);
        issue(1'b0, 6, 1'b0, 0, 1'b1, 0, "R6", r2);
        issue(1'b0, 7, 1'b0, 1, 1'b1, 5, "R6", q);
        chk(q - r2 == (BYPASS ? 1 : 2), "R6 consumer gap", q - r2, BYPASS ? 1 : 2);
        chk(q - p == gap_dep, "R6 producer to consumer", q - p, gap_dep);
        idle(8);

        // R7: constant with the same index as a pending temporary
        issue(1'b0, 2, 1'b0, 3, 1'b0, 4, "R7", p);
        issue(1'b1, 5, 1'b1, 2, 1'b1, 2, "R7", q);
        chk(q - p == 1, "R7 constant source no stall", q - p, 1);
        idle(8);

        // R8: overwrite of a pending destination, then read it
        issue(1'b1, 3, 1'b0, 1, 1'b0, 2, "R8", p);
        issue(1'b0, 3, 1'b1, 0, 1'b1, 7, "R8", q);
        chk(q - p == 4, "R8 overwrite gap", q - p, 4);
        issue(1'b0, 4, 1'b0, 3, 1'b1, 0, "R8", r0);
        chk(r0 - q == gap_dep, "R8 read after overwrite gap", r0 - q, gap_dep);
        idle(8);

        // R10: pseudo-random stream against the sequential model
        lfsr = 32'h0000ACE1;
        for (int n = 0; n < 60; n++) begin
            for (int s = 0; s < 16; s++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            end
            issue(lfsr[0], int'(lfsr[3:1]), lfsr[4], int'(lfsr[7:5]),
                  lfsr[8], int'(lfsr[11:9]), "R10 stream", p);
        end
        idle(10);
        chk(expq.size() == 0, "R10 all results stored", expq.size(), 0);
        done = 1'b1;
    end

endmodule

module alu_pipe_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic done_b, done_n;
    int   chk_b, chk_n, fail_b, fail_n;

    always #2.5 clk = ~clk;

    alu_pipe_harness #(.BYPASS(1'b1)) h_bypass (
        .clk (clk), .rst (rst), .done (done_b), .n_checks (chk_b), .n_fail (fail_b)
    );

    alu_pipe_harness #(.BYPASS(1'b0)) h_no_bypass (
        .clk (clk), .rst (rst), .done (done_n), .n_checks (chk_n), .n_fail (fail_n)
    );

    initial begin
        int wd, total, failed;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        wd = 0;
        while (!(done_b && done_n) && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        total  = chk_b + chk_n;
        failed = fail_b + fail_n;
        if (!(done_b && done_n)) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
        end
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule